// File: doc/BRIEF.md
# Asynchronous Serial Byte Receiver

This block recovers 8-bit bytes from one asynchronous serial line that idles high. Each frame is a low start bit, eight data bits sent least significant first, and a high stop bit. The line first passes through a two-flop synchronizer. A falling edge seen while idle starts a frame. The line is then sampled half a bit period later to confirm the start bit, and once per full bit period after that, so every data sample and the stop sample fall near the middle of their bit.

The bit period in clock cycles is the system clock frequency divided by the baud rate. Both are parameters, and the defaults are 50 MHz and 115200 baud. A frame that completes cleanly updates the byte output and raises a one-cycle valid strobe in the same cycle that busy drops. Two faults are flagged on separate outputs: a false start, where the line is high again at mid start bit, and a framing fault, where the stop bit is sampled low. A combined error output is also provided. Neither fault changes the byte output.

Top module: `serial_byte_rx`

## Requirements
- R1: The bit period is CLK_HZ/BAUD clock cycles, with HALF = period/2. Busy stays high for exactly HALF + 9*period cycles in a full frame, and for HALF cycles after a false start.
- R2: While idle, a falling edge on the synchronized line starts a frame and raises `rx_busy`. A line that stays high starts nothing.
- R3: The eight data bits are taken least significant bit first. Bit 0 of `rx_byte` is the first bit after the start bit.
- R4: After a frame whose stop bit is sampled high, `rx_byte` holds the received byte, `rx_busy` falls, and `rx_valid` is high for exactly one cycle, in the same cycle that busy first reads low.
- R5: If the line is high when sampled at mid start bit, `rx_err_start` and `rx_err` are set and the receiver returns to idle. `rx_valid` does not pulse and `rx_byte` is unchanged.
- R6: If the stop bit is sampled low, `rx_err_stop` and `rx_err` are set. `rx_valid` does not pulse and `rx_byte` keeps its previous value.
- R7: The error flags stay set until the next start edge is detected, and are cleared at that point. At most one of the two error flags is high at any time.
- R8: An active-low asynchronous reset forces idle at once: busy, valid and both error flags are low and `rx_byte` is zero. Reset release is synchronized to the clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_line | input | 1 | Asynchronous serial input, idle high |
| rx_byte | output | DATA_BITS | Last correctly framed byte |
| rx_valid | output | 1 | One-cycle strobe when a new byte is ready |
| rx_busy | output | 1 | High while a frame is being received |
| rx_err | output | 1 | Either error flag is set |
| rx_err_start | output | 1 | False start detected |
| rx_err_stop | output | 1 | Stop bit sampled low |

## Verification
Bytes with alternating bits, all zeros, all ones and a single set bit at either end are sent. They separate correct least-significant-first assembly from bit reversal and shift slips. The bench measures busy time in whole cycles, so an error in the half-period or full-period reload shows up directly. Frames with a low stop bit and glitch pulses shorter than half a bit exercise each error path separately, and each checks that the previous byte survives. A clean frame after an error confirms that the flag clears on the next start, and a reset in mid-frame confirms the asynchronous return to idle.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_START = 2'd1,
    ST_DATA  = 2'd2,
    ST_STOP  = 2'd3
  } rx_state_e;

  // Shift a new bit into the top; the first bit received ends up in bit 0.
  function automatic logic [7:0] push_lsb_first(input logic [7:0] cur, input logic b);
    return {b, cur[7:1]};
  endfunction

endpackage

// File: rtl/rx_sync2.sv
module rx_sync2 (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic sync_out,
  output logic fall
);
  logic meta_q, sync_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b1;
      sync_q <= 1'b1;
      prev_q <= 1'b1;
    end else begin
      meta_q <= async_in;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign sync_out = sync_q;
  assign fall     = prev_q & ~sync_q;

endmodule

// File: rtl/rx_bit_timer.sv
module rx_bit_timer #(
  parameter int BIT_CYC = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_half,
  input  logic active,
  output logic tick
);
  localparam int HALF_CYC = BIT_CYC / 2;
  localparam int CW       = (BIT_CYC > 2) ? $clog2(BIT_CYC) : 1;

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load_half)
      cnt_d = CW'(HALF_CYC - 1);
    else if (active)
      cnt_d = (cnt_q == '0) ? CW'(BIT_CYC - 1) : cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign tick = active & ~load_half & (cnt_q == '0);

  // R1: the counter never leaves its reload range
  a_r1_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(BIT_CYC - 1));

endmodule

// File: rtl/serial_byte_rx.sv
module serial_byte_rx
  import serial_rx_pkg::*;
#(
  parameter int CLK_HZ    = 50_000_000,
  parameter int BAUD      = 115_200,
  parameter int DATA_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rx_line,
  output logic [DATA_BITS-1:0] rx_byte,
  output logic                 rx_valid,
  output logic                 rx_busy,
  output logic                 rx_err,
  output logic                 rx_err_start,
  output logic                 rx_err_stop
);
  localparam int BIT_CYC = CLK_HZ / BAUD;
  localparam int BCW     = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;

  // reset: asserted asynchronously, released on a clock edge
  logic rst_a_q, rst_b_q, rst_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_a_q <= 1'b0;
      rst_b_q <= 1'b0;
    end else begin
      rst_a_q <= 1'b1;
      rst_b_q <= rst_a_q;
    end
  end
  assign rst_i = rst_b_q;

  logic line_s, line_fall, tick, load_half, timer_on;

  rx_sync2 u_sync (
    .clk      (clk),
    .rst_n    (rst_i),
    .async_in (rx_line),
    .sync_out (line_s),
    .fall     (line_fall)
  );

  rx_bit_timer #(.BIT_CYC(BIT_CYC)) u_timer (
    .clk       (clk),
    .rst_n     (rst_i),
    .load_half (load_half),
    .active    (timer_on),
    .tick      (tick)
  );

  rx_state_e            state_q, state_d;
  logic [BCW-1:0]       idx_q, idx_d;
  logic [DATA_BITS-1:0] shr_q, shr_d, byte_q, byte_d;
  logic                 valid_q, valid_d;
  logic                 errs_q, errs_d, errp_q, errp_d;

  assign timer_on = (state_q != ST_IDLE);

  // next state
  always_comb begin
    state_d   = state_q;
    idx_d     = idx_q;
    shr_d     = shr_q;
    byte_d    = byte_q;
    valid_d   = 1'b0;
    errs_d    = errs_q;
    errp_d    = errp_q;
    load_half = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (line_fall) begin
          state_d   = ST_START;
          load_half = 1'b1;
          errs_d    = 1'b0;
          errp_d    = 1'b0;
        end
      end
      ST_START: begin
        if (tick) begin
          if (line_s) begin
            state_d = ST_IDLE;
            errs_d  = 1'b1;
          end else begin
            state_d = ST_DATA;
            idx_d   = '0;
          end
        end
      end
      ST_DATA: begin
        if (tick) begin
          shr_d = {line_s, shr_q[DATA_BITS-1:1]};
          if (idx_q == BCW'(DATA_BITS - 1)) state_d = ST_STOP;
          else                              idx_d   = idx_q + 1'b1;
        end
      end
      ST_STOP: begin
        if (tick) begin
          state_d = ST_IDLE;
          if (line_s) begin
            byte_d  = shr_q;
            valid_d = 1'b1;
          end else begin
            errp_d  = 1'b1;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      shr_q   <= '0;
      byte_q  <= '0;
      valid_q <= 1'b0;
      errs_q  <= 1'b0;
      errp_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      shr_q   <= shr_d;
      byte_q  <= byte_d;
      valid_q <= valid_d;
      errs_q  <= errs_d;
      errp_q  <= errp_d;
    end
  end

  assign rx_byte      = byte_q;
  assign rx_valid     = valid_q;
  assign rx_busy      = timer_on;
  assign rx_err_start = errs_q;
  assign rx_err_stop  = errp_q;
  assign rx_err       = errs_q | errp_q;

  // R4: valid is a single-cycle strobe
  a_r4_valid_pulse: assert property (@(posedge clk) disable iff (!rst_i)
    rx_valid |=> !rx_valid);
  // R4: a byte is announced only once the frame is over
  a_r4_valid_not_busy: assert property (@(posedge clk) disable iff (!rst_i)
    rx_valid |-> !rx_busy);
  // R5/R6: the byte output moves only together with a valid strobe
  a_r6_byte_hold: assert property (@(posedge clk) disable iff (!rst_i)
    !$stable(rx_byte) |-> rx_valid);
  // R7: the two error kinds never coexist
  a_r7_err_exclusive: assert property (@(posedge clk) disable iff (!rst_i)
    !(rx_err_start && rx_err_stop));
  // R7: a new frame begins with the error flags cleared
  a_r7_err_clear: assert property (@(posedge clk) disable iff (!rst_i)
    $rose(rx_busy) |-> !rx_err);
  // R2: a frame starts only from a falling edge
  a_r2_start_edge: assert property (@(posedge clk) disable iff (!rst_i)
    $rose(rx_busy) |-> $past(line_fall));

endmodule

// File: tb/tb_serial_byte_rx.sv
module tb_serial_byte_rx;
  localparam int CLK_HZ = 160;
  localparam int BAUD   = 10;
  localparam int BITC   = CLK_HZ / BAUD;
  localparam int HALFC  = BITC / 2;
  localparam int FRAME_BUSY = HALFC + 9 * BITC;

  typedef struct packed {
    logic [7:0] data;
    logic       bad_stop;
    logic       false_start;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{8'h55, 1'b0, 1'b0},
    '{8'hA5, 1'b0, 1'b0},
    '{8'h00, 1'b0, 1'b0},
    '{8'hFF, 1'b0, 1'b0},
    '{8'h01, 1'b0, 1'b0},
    '{8'h80, 1'b0, 1'b0},
    '{8'h3C, 1'b1, 1'b0},
    '{8'h00, 1'b0, 1'b1},
    '{8'hC3, 1'b0, 1'b0},
    '{8'h7E, 1'b1, 1'b0}
  };

  logic clk = 1'b0;
  logic rst_n;
  logic rx_line;
  logic [7:0] rx_byte;
  logic rx_valid, rx_busy, rx_err, rx_err_start, rx_err_stop;

  always #4 clk = ~clk;

  serial_byte_rx #(.CLK_HZ(CLK_HZ), .BAUD(BAUD), .DATA_BITS(8)) dut (
    .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .rx_byte(rx_byte),
    .rx_valid(rx_valid), .rx_busy(rx_busy), .rx_err(rx_err),
    .rx_err_start(rx_err_start), .rx_err_stop(rx_err_stop)
  );

  int n_tests = 0;
  int n_fail  = 0;
  int busy_cyc = 0;
  int vcnt = 0;
  logic done = 1'b0;

  always @(negedge clk) begin
    if (rx_busy)  busy_cyc++;
    if (rx_valid) begin
      vcnt++;
      if (rx_busy) begin
        n_tests++; n_fail++;
        $display("FAIL R4: valid with busy high (busy=%0d exp 0)", rx_busy);
      end
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle_bits(input int nb);
    repeat (nb * BITC) @(negedge clk);
  endtask

  task automatic send_frame(input logic [7:0] d, input logic bad_stop, input logic check_busy);
    @(negedge clk) rx_line = 1'b0;
    repeat (BITC) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rx_line = d[i];
      repeat (BITC) @(negedge clk);
      if (check_busy && i == 2) check("R2 busy mid-frame", rx_busy, 1);
    end
    rx_line = ~bad_stop;
    repeat (BITC) @(negedge clk);
    rx_line = 1'b1;
  endtask

  task automatic send_glitch();
    @(negedge clk) rx_line = 1'b0;
    repeat (HALFC / 2) @(negedge clk);
    rx_line = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] exp_byte;
    int b0, v0;
    rx_line = 1'b1;
    rst_n = 1'b0;
    repeat (5) @(negedge clk);
    // R8: reset state
    check("R8 busy in reset", rx_busy, 0);
    check("R8 byte in reset", rx_byte, 0);
    check("R8 err in reset", rx_err, 0);
    check("R8 valid in reset", rx_valid, 0);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    // R2: idle-high line starts nothing
    b0 = busy_cyc;
    idle_bits(3);
    check("R2 no start on idle line", busy_cyc - b0, 0);

    exp_byte = 8'h00;
    for (int k = 0; k < NV; k++) begin
      b0 = busy_cyc; v0 = vcnt;
      if (VECS[k].false_start) begin
        send_glitch();
        idle_bits(2);
        check("R5 err_start", rx_err_start, 1);
        check("R5 err", rx_err, 1);
        check("R5 no valid", vcnt - v0, 0);
        check("R5 byte kept", rx_byte, exp_byte);
        check("R1 busy after false start", busy_cyc - b0, HALFC);
      end else begin
        send_frame(VECS[k].data, VECS[k].bad_stop, 1'b1);
        idle_bits(2);
        check("R4 busy low after frame", rx_busy, 0);
        check("R1 busy length", busy_cyc - b0, FRAME_BUSY);
        if (VECS[k].bad_stop) begin
          check("R6 err_stop", rx_err_stop, 1);
          check("R6 err", rx_err, 1);
          check("R6 no valid", vcnt - v0, 0);
          check("R6 byte kept", rx_byte, exp_byte);
        end else begin
          exp_byte = VECS[k].data;
          check("R3 byte LSB first", rx_byte, exp_byte);
          check("R4 one valid", vcnt - v0, 1);
          check("R7 no err after good frame", rx_err, 0);
          check("R7 err_start clear", rx_err_start, 0);
        end
      end
    end

    // R7: the flag from the last bad-stop frame clears on the next start
    check("R7 err held while idle", rx_err_stop, 1);
    fork
      send_frame(8'h96, 1'b0, 1'b0);
      begin
        repeat (BITC) @(negedge clk);
        check("R7 err cleared at start", rx_err, 0);
      end
    join
    idle_bits(2);
    check("R3 byte after recovery", rx_byte, 8'h96);

    // R8: reset in mid-frame
    @(negedge clk) rx_line = 1'b0;
    repeat (3 * BITC) @(negedge clk);
    check("R8 busy before reset", rx_busy, 1);
    #1 rst_n = 1'b0;
    #1 check("R8 busy async clear", rx_busy, 0);
    check("R8 byte cleared", rx_byte, 0);
    rx_line = 1'b1;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    idle_bits(2);
    check("R8 idle after release", rx_busy, 0);
    check("R8 err after release", rx_err, 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule